// File: doc/BRIEF.md
# Debug Breakpoint Trap Unit

This block is the breakpoint comparator of an in-circuit debug facility for a small 8-bit controller whose program memory is addressed with 15 bits and whose data memory uses an 8-bit address and an 8-bit data bus. Software programs it through two ports: an index port chooses one of four internal registers (mode, data mask, compare low, compare high), and a data port writes or reads the chosen one.

The unit watches the program fetch address, or the data memory address and data together with their read and write strobes. When an enabled condition matches, it raises a trap request for one clock. With single step enabled, it raises one after every completed instruction. Reading the mode register shows whether the last memory trap came from a read or a write cycle. The logic that halts the processor on a trap is not part of this block.

Top module: `dbg_trap_unit`

## Requirements
- R1: After reset trap_o is 0 and all four registers read back as 00h.
- R2: Writing the index port with idx_we_i stores wdata_i[1:0] as the index (0 mode, 1 data mask, 2 compare low, 3 compare high). dat_we_i writes wdata_i into the indexed register. rdata_o always shows the indexed register, and registers 1 to 3 read back exactly as written.
- R3: With mode bit 0 set, a cycle with fetch_i high and fetch_addr_i equal to {compare high bits 6:0, compare low} traps. Bit 7 of compare high is ignored, and memory cycles never trap in this mode.
- R4: With mode bit 1 set, a memory cycle whose address equals compare low traps. It must be a read with mode bit 4 set or a write with mode bit 3 set. Modes 12h, 0Ah and 1Ah therefore trap on read, write and either.
- R5: With mode bit 2 set, the memory data must also match compare high on every bit where the mask register holds 1; mask bits that are 0 are ignored (modes 16h, 0Eh, 1Eh).
- R6: A memory cycle whose direction is not enabled by bit 3 or bit 4 never traps, even when its address and data match.
- R7: Reading register 0 returns mode bits 7 and 4:0 as written. Bit 6 reads 1 after a trap caused by a read cycle and bit 5 reads 1 after one caused by a write cycle. Both are cleared whenever the mode register is written, and values written to bits 5 and 6 are not stored.
- R8: trap_o goes high in the clock cycle after the one in which the matching strobe is sampled, and stays high for one cycle per matching strobe cycle.
- R9: With mode bit 7 set, every cycle with insn_done_i high produces a trap, including on back-to-back cycles.
- R10: With mode 00h no fetch, memory or instruction-complete cycle produces a trap.
- R11: When a single-step event and a memory match occur in the same cycle, exactly one trap pulse results and the cause bit is still set. When the mode register is written in the same cycle as a match, the match is judged against the old settings, but the clear of the cause bits wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_we_i | input | 1 | Write strobe for the index port |
| dat_we_i | input | 1 | Write strobe for the data port |
| wdata_i | input | 8 | Write data for both ports |
| rdata_o | output | 8 | Contents of the indexed register |
| fetch_i | input | 1 | Program fetch strobe |
| fetch_addr_i | input | 15 | Program fetch address |
| mem_rd_i | input | 1 | Data memory read strobe |
| mem_wr_i | input | 1 | Data memory write strobe |
| mem_addr_i | input | 8 | Data memory address |
| mem_data_i | input | 8 | Data memory data |
| insn_done_i | input | 1 | Instruction completed |
| trap_o | output | 1 | Trap request, one cycle per event |

## Verification
Two pairs of functions can coincide. In one pair, a single-step event lands on the same cycle as a read that matches the memory address; the bench checks for exactly one trap pulse and for the read-cause bit set in the mode readback. In the other pair, a mode write on the data port lands on the same cycle as a matching read. Here the trap must still fire from the old settings, while the readback must show the cause bits cleared.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int unsigned DW = 8;

  localparam logic [1:0] IDX_MODE = 2'd0;
  localparam logic [1:0] IDX_MASK = 2'd1;
  localparam logic [1:0] IDX_CLO  = 2'd2;
  localparam logic [1:0] IDX_CHI  = 2'd3;

  localparam int unsigned MB_ROM   = 0;
  localparam int unsigned MB_MADDR = 1;
  localparam int unsigned MB_MDATA = 2;
  localparam int unsigned MB_QWR   = 3;
  localparam int unsigned MB_QRD   = 4;
  localparam int unsigned MB_CWR   = 5;
  localparam int unsigned MB_CRD   = 6;
  localparam int unsigned MB_STEP  = 7;

  typedef struct packed {
    logic [DW-1:0] mode;
    logic [DW-1:0] mask;
    logic [DW-1:0] clo;
    logic [DW-1:0] chi;
  } dbg_cfg_t;
endpackage

// File: rtl/dbg_regs.sv
module dbg_regs
  import dbg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idx_we_i,
  input  logic          dat_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          cause_rd_i,
  input  logic          cause_wr_i,
  output dbg_cfg_t      cfg_o,
  output logic          mode_we_o,
  output logic [DW-1:0] rdata_o
);
  localparam logic [DW-1:0] MODE_KEEP = DW'((1 << (MB_STEP + 1)) - 1)
                                      & ~DW'(1 << MB_CWR) & ~DW'(1 << MB_CRD);

  logic [1:0] idx_q;
  dbg_cfg_t   cfg_q;

  assign mode_we_o = dat_we_i && (idx_q == IDX_MODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      cfg_q <= '0;
    end else begin
      if (idx_we_i) idx_q <= wdata_i[1:0];
      if (dat_we_i) begin
        unique case (idx_q)
          IDX_MODE: cfg_q.mode <= wdata_i & MODE_KEEP;
          IDX_MASK: cfg_q.mask <= wdata_i;
          IDX_CLO:  cfg_q.clo  <= wdata_i;
          default:  cfg_q.chi  <= wdata_i;
        endcase
      end
    end
  end

  assign cfg_o = cfg_q;

  always_comb begin
    unique case (idx_q)
      IDX_MODE: begin
        rdata_o         = cfg_q.mode;
        rdata_o[MB_CRD] = cause_rd_i;
        rdata_o[MB_CWR] = cause_wr_i;
      end
      IDX_MASK: rdata_o = cfg_q.mask;
      IDX_CLO:  rdata_o = cfg_q.clo;
      default:  rdata_o = cfg_q.chi;
    endcase
  end

  a_r7_cause_bits_not_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_o |=> (cfg_o.mode[MB_CRD] == 1'b0 && cfg_o.mode[MB_CWR] == 1'b0));
endmodule

// File: rtl/dbg_match.sv
module dbg_match
  import dbg_pkg::*;
#(
  parameter int unsigned ROM_AW = 15,
  parameter int unsigned MAW    = 8
) (
  input  dbg_cfg_t          cfg_i,
  input  logic              fetch_i,
  input  logic [ROM_AW-1:0] fetch_addr_i,
  input  logic              mem_rd_i,
  input  logic              mem_wr_i,
  input  logic [MAW-1:0]    mem_addr_i,
  input  logic [DW-1:0]     mem_data_i,
  input  logic              insn_done_i,
  output logic              rom_hit_o,
  output logic              rd_hit_o,
  output logic              wr_hit_o,
  output logic              step_hit_o
);
  localparam int unsigned HI_W = ROM_AW - DW;

  logic [ROM_AW-1:0] rom_target;
  logic              mem_mode, addr_ok, data_ok;

  assign rom_target = {cfg_i.chi[HI_W-1:0], cfg_i.clo};
  assign rom_hit_o  = cfg_i.mode[MB_ROM] && fetch_i && (fetch_addr_i == rom_target);

  // memory compares run only when the compare registers are not holding a ROM address
  assign mem_mode = !cfg_i.mode[MB_ROM] && (cfg_i.mode[MB_MADDR] || cfg_i.mode[MB_MDATA]);
  assign addr_ok  = !cfg_i.mode[MB_MADDR] || (mem_addr_i == cfg_i.clo[MAW-1:0]);
  assign data_ok  = !cfg_i.mode[MB_MDATA] || (((mem_data_i ^ cfg_i.chi) & cfg_i.mask) == '0);

  assign rd_hit_o   = mem_mode && addr_ok && data_ok && mem_rd_i && cfg_i.mode[MB_QRD];
  assign wr_hit_o   = mem_mode && addr_ok && data_ok && mem_wr_i && cfg_i.mode[MB_QWR];
  assign step_hit_o = cfg_i.mode[MB_STEP] && insn_done_i;
endmodule

// File: rtl/dbg_trap_gen.sv
module dbg_trap_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rom_hit_i,
  input  logic rd_hit_i,
  input  logic wr_hit_i,
  input  logic step_hit_i,
  input  logic mode_we_i,
  output logic trap_o,
  output logic cause_rd_o,
  output logic cause_wr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_o     <= 1'b0;
      cause_rd_o <= 1'b0;
      cause_wr_o <= 1'b0;
    end else begin
      trap_o <= rom_hit_i || rd_hit_i || wr_hit_i || step_hit_i;
      if (mode_we_i) begin
        cause_rd_o <= 1'b0;
        cause_wr_o <= 1'b0;
      end else begin
        if (rd_hit_i) cause_rd_o <= 1'b1;
        if (wr_hit_i) cause_wr_o <= 1'b1;
      end
    end
  end

  a_r7_clear_on_mode_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> (!cause_rd_o && !cause_wr_o));
  a_r7_rd_cause_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit_i && !mode_we_i) |=> cause_rd_o);
  a_r8_trap_follows_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit_i || wr_hit_i) |=> trap_o);
endmodule

// File: rtl/dbg_trap_unit.sv
module dbg_trap_unit
  import dbg_pkg::*;
#(
  parameter int unsigned ROM_AW = 15,
  parameter int unsigned MAW    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_we_i,
  input  logic              dat_we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              fetch_i,
  input  logic [ROM_AW-1:0] fetch_addr_i,
  input  logic              mem_rd_i,
  input  logic              mem_wr_i,
  input  logic [MAW-1:0]    mem_addr_i,
  input  logic [DW-1:0]     mem_data_i,
  input  logic              insn_done_i,
  output logic              trap_o
);
  dbg_cfg_t cfg;
  logic     mode_we, cause_rd, cause_wr;
  logic     rom_hit, rd_hit, wr_hit, step_hit;

  dbg_regs u_regs (
    .clk_i, .rst_ni, .idx_we_i, .dat_we_i, .wdata_i,
    .cause_rd_i(cause_rd), .cause_wr_i(cause_wr),
    .cfg_o(cfg), .mode_we_o(mode_we), .rdata_o
  );

  dbg_match #(.ROM_AW(ROM_AW), .MAW(MAW)) u_match (
    .cfg_i(cfg), .fetch_i, .fetch_addr_i, .mem_rd_i, .mem_wr_i,
    .mem_addr_i, .mem_data_i, .insn_done_i,
    .rom_hit_o(rom_hit), .rd_hit_o(rd_hit), .wr_hit_o(wr_hit), .step_hit_o(step_hit)
  );

  dbg_trap_gen u_trap (
    .clk_i, .rst_ni, .rom_hit_i(rom_hit), .rd_hit_i(rd_hit), .wr_hit_i(wr_hit),
    .step_hit_i(step_hit), .mode_we_i(mode_we),
    .trap_o, .cause_rd_o(cause_rd), .cause_wr_o(cause_wr)
  );

  a_r10_disabled_no_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.mode == '0) |=> !trap_o);
  a_r9_step_traps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.mode[MB_STEP] && insn_done_i) |=> trap_o);
  a_r3_rom_mode_ignores_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.mode[MB_ROM] && !fetch_i && !(cfg.mode[MB_STEP] && insn_done_i)) |=> !trap_o);
  a_r6_one_cause_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_hit && !mem_rd_i) && !(wr_hit && !mem_wr_i));
endmodule

// File: tb/dbg_trap_unit_test.sv
module dbg_trap_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_we = 0, dat_we = 0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        fetch = 0;
  logic [14:0] fetch_addr = '0;
  logic        mem_rd = 0, mem_wr = 0;
  logic [7:0]  mem_addr = '0, mem_data = '0;
  logic        insn_done = 0;
  logic        trap;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dbg_trap_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .idx_we_i(idx_we), .dat_we_i(dat_we), .wdata_i(wdata),
    .rdata_o(rdata), .fetch_i(fetch), .fetch_addr_i(fetch_addr), .mem_rd_i(mem_rd),
    .mem_wr_i(mem_wr), .mem_addr_i(mem_addr), .mem_data_i(mem_data),
    .insn_done_i(insn_done), .trap_o(trap)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] idx, input logic [7:0] val);
    @(negedge clk); idx_we = 1; wdata = {6'd0, idx};
    @(negedge clk); idx_we = 0; dat_we = 1; wdata = val;
    @(negedge clk); dat_we = 0;
  endtask

  task automatic rd_reg(input logic [1:0] idx, input logic [7:0] exp, input string tag);
    @(negedge clk); idx_we = 1; wdata = {6'd0, idx};
    @(negedge clk); idx_we = 0;
    chk(tag, rdata, exp);
  endtask

  // one strobe cycle, trap sampled the cycle after, then pulse end
  task automatic access(input bit rd, input bit wr, input bit fe, input bit st,
                        input logic [14:0] fa, input logic [7:0] ma, input logic [7:0] md,
                        input bit exp_trap, input string tag);
    @(negedge clk);
    mem_rd = rd; mem_wr = wr; fetch = fe; insn_done = st;
    fetch_addr = fa; mem_addr = ma; mem_data = md;
    @(negedge clk);
    mem_rd = 0; mem_wr = 0; fetch = 0; insn_done = 0;
    chk(tag, trap, exp_trap);
    @(negedge clk);
    chk({tag, " pulse end R8"}, trap, 0);
  endtask

  task automatic t_reset;
    chk("R1 trap after reset", trap, 0);
    for (int i = 0; i < 4; i++) rd_reg(i[1:0], 8'h00, "R1 reg reset value");
  endtask

  task automatic t_regs;
    wr_reg(1, 8'hAA); wr_reg(2, 8'h34); wr_reg(3, 8'h56);
    rd_reg(1, 8'hAA, "R2 mask readback");
    rd_reg(2, 8'h34, "R2 compare low readback");
    rd_reg(3, 8'h56, "R2 compare high readback");
    wr_reg(0, 8'hFF);
    rd_reg(0, 8'h9F, "R7 cause bits not writable");
  endtask

  task automatic t_rom;
    wr_reg(2, 8'h34); wr_reg(3, 8'h92); wr_reg(0, 8'h01);
    access(0, 0, 1, 0, 15'h1234, 8'h00, 8'h00, 1, "R3 rom fetch match, bit7 ignored");
    access(0, 0, 1, 0, 15'h1235, 8'h00, 8'h00, 0, "R3 rom fetch mismatch");
    access(1, 0, 0, 0, 15'h0000, 8'h34, 8'h92, 0, "R3 memory ignored in rom mode");
  endtask

  task automatic t_addr;
    wr_reg(2, 8'h40); wr_reg(0, 8'h12);
    access(1, 0, 0, 0, '0, 8'h40, 8'h00, 1, "R4 read at address, mode 12h");
    rd_reg(0, 8'h52, "R7 read cause bit");
    access(0, 1, 0, 0, '0, 8'h40, 8'h00, 0, "R6 write ignored in mode 12h");
    access(1, 0, 0, 0, '0, 8'h41, 8'h00, 0, "R4 read at other address");
    wr_reg(0, 8'h0A);
    rd_reg(0, 8'h0A, "R7 causes cleared by mode write");
    access(0, 1, 0, 0, '0, 8'h40, 8'h00, 1, "R4 write at address, mode 0Ah");
    access(1, 0, 0, 0, '0, 8'h40, 8'h00, 0, "R6 read ignored in mode 0Ah");
    rd_reg(0, 8'h2A, "R7 write cause bit");
    wr_reg(0, 8'h1A);
    access(1, 0, 0, 0, '0, 8'h40, 8'h00, 1, "R4 read in mode 1Ah");
    access(0, 1, 0, 0, '0, 8'h40, 8'h00, 1, "R4 write in mode 1Ah");
    rd_reg(0, 8'h7A, "R7 both cause bits");
  endtask

  task automatic t_data;
    wr_reg(2, 8'h40); wr_reg(3, 8'hA5); wr_reg(1, 8'hF0); wr_reg(0, 8'h16);
    access(1, 0, 0, 0, '0, 8'h40, 8'hA3, 1, "R5 masked data match on read");
    access(1, 0, 0, 0, '0, 8'h40, 8'hB5, 0, "R5 unmasked data mismatch");
    access(1, 0, 0, 0, '0, 8'h41, 8'hA5, 0, "R5 address mismatch with data match");
    access(0, 1, 0, 0, '0, 8'h40, 8'hA5, 0, "R6 write ignored in mode 16h");
    wr_reg(0, 8'h0E);
    access(0, 1, 0, 0, '0, 8'h40, 8'hA0, 1, "R5 masked data match on write, mode 0Eh");
    wr_reg(1, 8'hFF);
    access(0, 1, 0, 0, '0, 8'h40, 8'hA0, 0, "R5 full mask mismatch");
  endtask

  task automatic t_step;
    wr_reg(0, 8'h80);
    for (int i = 0; i < 3; i++)
      access(0, 0, 0, 1, '0, 8'h00, 8'h00, 1, "R9 step trap");
    @(negedge clk); insn_done = 1;
    @(negedge clk); chk("R9 back-to-back step first", trap, 1);
    @(negedge clk); insn_done = 0; chk("R9 back-to-back step second", trap, 1);
    @(negedge clk); chk("R8 step pulse ends", trap, 0);
    rd_reg(0, 8'h80, "R9 mode readback");
  endtask

  task automatic t_off;
    wr_reg(2, 8'h40); wr_reg(3, 8'h00); wr_reg(0, 8'h00);
    access(1, 1, 1, 1, 15'h0040, 8'h40, 8'h00, 0, "R10 disabled, no trap");
  endtask

  task automatic t_same;
    wr_reg(1, 8'h00); wr_reg(2, 8'h40); wr_reg(0, 8'h9A);
    access(1, 0, 0, 1, '0, 8'h40, 8'h00, 1, "R11 step and read match together");
    rd_reg(0, 8'hDA, "R11 read cause with step");
    // index is 0 now; mode write coincides with a matching read
    @(negedge clk); dat_we = 1; wdata = 8'h9A; mem_rd = 1; mem_addr = 8'h40;
    @(negedge clk); dat_we = 0; mem_rd = 0;
    chk("R11 match with concurrent mode write still traps", trap, 1);
    chk("R11 clear wins over set", rdata, 8'h9A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_rom();
    t_addr();
    t_data();
    t_step();
    t_off();
    t_same();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule